// File: doc/BRIEF.md
# Configurable Debug Breakpoint Unit

The block sits beside a processor core and watches two streams: the address of each instruction as it completes, and the address and direction of each data-memory access. It holds four address comparators. Slots 0 and 1 always watch program addresses. Slots 2 and 3 are shared: each can watch program or data addresses. In pair mode slot 3 becomes a bit mask for slot 2, so that the two together form one range-style match. The block also breaks on any taken change of program flow, and it has a single-step mode that breaks when an instruction completes.

Every condition that fires sets its own sticky status bit. The break request is the OR of those bits. It stays raised until the debugger pulses the clear input. Configuration is loaded through a one-cycle write port. A control word that describes an impossible pairing is rejected, and the previous setup stays in force. Transport to the debugger, the core's scan path and the act of halting the core are left to the blocks around it.

Top module: `brk_unit`

## Requirements
- R1: After reset, brk_req_o is 0 and brk_hit_o is 0. Every slot, flow and step enable is cleared, so no stimulus produces a hit until a control word is written.
- R2: Register addresses 0..3 load the base address of slots 0..3. Address 4 loads the control word: bits 3:0 enable slots 3..0; bit 4 sets slot 2 to data (1) or program (0); bit 5 does the same for slot 3; bit 6 selects pair mode; bit 7 enables the flow break; bit 8 enables the step break; bits 9 and 10 allow slot 2 to match data reads and data writes; bits 11 and 12 do the same for slot 3; bit 13 is the global enable. Slots 0 and 1, when enabled, set brk_hit_o bit 0 and bit 1 when pc_valid_i is high and pc_i equals their base.
- R3: A combined slot set to program behaves as in R2. A combined slot set to data matches only when d_valid_i is high, d_addr_i equals its base, and its read-enable bit (for d_we_i=0) or write-enable bit (for d_we_i=1) is set. It then ignores the program stream. Slot 2 reports on bit 2 and slot 3 on bit 3.
- R4: In pair mode, slot 2 matches when ((addr XOR base2) AND base3) is zero. A mask bit of 1 means the address bit is compared. The address is taken from the stream that slot 2's target bit selects, and the match is reported on bit 2. Bit 3 never fires in pair mode.
- R5: A control write is illegal when pair mode is set together with either the slot 3 enable or unequal target bits for slots 2 and 3. An illegal write leaves the whole previous control word in effect.
- R6: When the flow break is enabled, a cycle with pc_valid_i and pc_flow_i both high sets brk_hit_o bit 4.
- R7: When the step break is enabled, each cycle with pc_valid_i high sets brk_hit_o bit 5.
- R8: While the global enable is 0, no condition sets any status bit.
- R9: Status bits are sticky. They hold until brk_clr_i is high for one cycle, and then they clear. A hit that occurs in the same cycle as the clear is kept. brk_req_o is high exactly when any status bit is set.
- R10: A qualifying input sampled at a clock edge shows on brk_hit_o and brk_req_o just after that edge and not before it. There is no combinational path from the watched streams to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select (0..3 bases, 4 control) |
| cfg_wdata_i | input | DW (16) | Configuration write data |
| pc_valid_i | input | 1 | An instruction completed at pc_i this cycle |
| pc_i | input | PA_W (16) | Program address of the completed instruction |
| pc_flow_i | input | 1 | That instruction was a taken jump, branch, call, return or interrupt entry |
| d_valid_i | input | 1 | A data-memory access occurs this cycle |
| d_addr_i | input | DA_W (16) | Data access address |
| d_we_i | input | 1 | Data access is a write (1) or a read (0) |
| brk_clr_i | input | 1 | Clears all status bits |
| brk_req_o | output | 1 | Sticky break request |
| brk_hit_o | output | 6 | Status: bits 0..3 slots, bit 4 flow, bit 5 step |

## Verification
The hardest states to reach are the masked range match in its data form and the rejection of illegal pairings. Both need several register writes in the right order before any stream activity: slot 3 must already hold a mask, and the pair bit must arrive in the same word as matching targets. Each row of the stimulus table therefore writes slot 3's value and then a full control word, clears the status, and drives one stream event. A later directed sequence first installs a legal setup and then tries two illegal words. The illegal words are chosen so that accepting either one would change which addresses hit.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int unsigned NSLOT  = 4;
  localparam int unsigned NHIT   = NSLOT + 2;
  localparam int unsigned CTRL_W = 14;
  localparam int unsigned HIT_FLOW = NSLOT;
  localparam int unsigned HIT_STEP = NSLOT + 1;
  localparam logic [2:0]  CTRL_ADDR = 3'd4;

  // control word, MSB first (bit 13 down to bit 0)
  typedef struct packed {
    logic       gen;
    logic       w3;
    logic       r3;
    logic       w2;
    logic       r2;
    logic       step;
    logic       flow;
    logic       pair;
    logic       t3;
    logic       t2;
    logic [3:0] en;
  } brk_ctrl_t;

  function automatic logic ctrl_legal(brk_ctrl_t c);
    return !(c.pair && (c.en[3] || (c.t2 != c.t3)));
  endfunction

endpackage

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [2:0]                 addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NSLOT-1:0][AW-1:0]   base_o,
  output brk_ctrl_t                  ctrl_o
);

  logic [NSLOT-1:0][AW-1:0] base_q, base_d;
  brk_ctrl_t                ctrl_q, ctrl_d;
  brk_ctrl_t                wctrl;
  logic                     base_sel;
  logic                     ctrl_sel;

  assign wctrl    = brk_ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign base_sel = we_i && (addr_i < 3'(NSLOT));
  assign ctrl_sel = we_i && (addr_i == CTRL_ADDR);

  always_comb begin
    base_d = base_q;
    ctrl_d = ctrl_q;
    if (base_sel) begin
      base_d[addr_i[1:0]] = wdata_i[AW-1:0];
    end
    if (ctrl_sel && ctrl_legal(wctrl)) begin
      ctrl_d = wctrl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (base_sel) base_q <= base_d;
      if (ctrl_sel) ctrl_q <= ctrl_d;
    end
  end

  assign base_o = base_q;
  assign ctrl_o = ctrl_q;

  // R5: an illegal pairing never reaches the live control word
  a_r5_illegal_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_sel && (wctrl.pair && (wctrl.en[3] || (wctrl.t2 != wctrl.t3))))
      |=> $stable(ctrl_q));

  // R5: the live control word is always one of the legal forms
  a_r5_live_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q.pair && ctrl_q.en[3]));

endmodule

// File: rtl/brk_slot.sv
module brk_slot #(
  parameter int unsigned AW   = 16,
  parameter int unsigned PA_W = 16,
  parameter int unsigned DA_W = 16
) (
  input  logic            en_i,
  input  logic            is_data_i,
  input  logic            use_mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   mask_i,
  input  logic            rd_en_i,
  input  logic            wr_en_i,
  input  logic            pc_valid_i,
  input  logic [PA_W-1:0] pc_i,
  input  logic            d_valid_i,
  input  logic [DA_W-1:0] d_addr_i,
  input  logic            d_we_i,
  output logic            hit_o
);

  logic [AW-1:0] pc_x;
  logic [AW-1:0] d_x;
  logic [AW-1:0] sel_addr;
  logic [AW-1:0] eff_mask;
  logic          qual;
  logic          match;

  assign pc_x = AW'(pc_i);
  assign d_x  = AW'(d_addr_i);

  always_comb begin
    sel_addr = is_data_i ? d_x : pc_x;
    eff_mask = use_mask_i ? mask_i : '1;
    if (is_data_i) begin
      qual = d_valid_i && (d_we_i ? wr_en_i : rd_en_i);
    end else begin
      qual = pc_valid_i;
    end
    match = (((sel_addr ^ base_i) & eff_mask) == '0);
    hit_o = en_i && qual && match;
  end

endmodule

// File: rtl/brk_event.sv
module brk_event (
  input  logic flow_en_i,
  input  logic step_en_i,
  input  logic pc_valid_i,
  input  logic pc_flow_i,
  output logic flow_hit_o,
  output logic step_hit_o
);

  always_comb begin
    flow_hit_o = flow_en_i && pc_valid_i && pc_flow_i;
    step_hit_o = step_en_i && pc_valid_i;
  end

endmodule

// File: rtl/brk_status.sv
module brk_status #(
  parameter int unsigned NHIT = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NHIT-1:0] hit_i,
  input  logic            gen_i,
  input  logic            clr_i,
  output logic [NHIT-1:0] status_o
);

  logic [NHIT-1:0] status_q, status_d;
  logic [NHIT-1:0] keep;
  logic [NHIT-1:0] fresh;
  logic            upd;

  always_comb begin
    keep     = clr_i ? '0 : status_q;
    fresh    = gen_i ? hit_i : '0;
    status_d = keep | fresh;
    upd      = clr_i || (|fresh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (upd) begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  // R9: set bits survive every cycle without a clear
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9: a clear with no new hit empties the status
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (hit_i == '0)) |=> (status_q == '0));

  // R8: with the global enable low, nothing new is set
  a_r8_gen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |=> ((status_q & ~$past(status_q)) == '0));

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int unsigned PA_W = 16,
  parameter int unsigned DA_W = 16,
  localparam int unsigned AW  = (PA_W > DA_W) ? PA_W : DA_W,
  localparam int unsigned DW  = (AW > CTRL_W) ? AW : CTRL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  input  logic            pc_valid_i,
  input  logic [PA_W-1:0] pc_i,
  input  logic            pc_flow_i,
  input  logic            d_valid_i,
  input  logic [DA_W-1:0] d_addr_i,
  input  logic            d_we_i,
  input  logic            brk_clr_i,
  output logic            brk_req_o,
  output logic [NHIT-1:0] brk_hit_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NSLOT-1:0][AW-1:0] base;
  brk_ctrl_t                ctrl;
  logic [NSLOT-1:0]         slot_hit;
  logic                     flow_hit;
  logic                     step_hit;
  logic [NHIT-1:0]          hit_now;
  logic [NHIT-1:0]          status;

  brk_cfg #(.AW(AW), .DW(DW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base),
    .ctrl_o  (ctrl)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic slot_en, slot_data, slot_mask, slot_rd, slot_wr;
    if (g < 2) begin : g_prog
      assign slot_en   = ctrl.en[g];
      assign slot_data = 1'b0;
      assign slot_mask = 1'b0;
      assign slot_rd   = 1'b0;
      assign slot_wr   = 1'b0;
    end else if (g == 2) begin : g_lead
      assign slot_en   = ctrl.en[2];
      assign slot_data = ctrl.t2;
      assign slot_mask = ctrl.pair;
      assign slot_rd   = ctrl.r2;
      assign slot_wr   = ctrl.w2;
    end else begin : g_partner
      assign slot_en   = ctrl.en[3] && !ctrl.pair;
      assign slot_data = ctrl.t3;
      assign slot_mask = 1'b0;
      assign slot_rd   = ctrl.r3;
      assign slot_wr   = ctrl.w3;
    end

    brk_slot #(.AW(AW), .PA_W(PA_W), .DA_W(DA_W)) u_slot (
      .en_i       (slot_en),
      .is_data_i  (slot_data),
      .use_mask_i (slot_mask),
      .base_i     (base[g]),
      .mask_i     (base[NSLOT-1]),
      .rd_en_i    (slot_rd),
      .wr_en_i    (slot_wr),
      .pc_valid_i (pc_valid_i),
      .pc_i       (pc_i),
      .d_valid_i  (d_valid_i),
      .d_addr_i   (d_addr_i),
      .d_we_i     (d_we_i),
      .hit_o      (slot_hit[g])
    );
  end

  brk_event u_event (
    .flow_en_i  (ctrl.flow),
    .step_en_i  (ctrl.step),
    .pc_valid_i (pc_valid_i),
    .pc_flow_i  (pc_flow_i),
    .flow_hit_o (flow_hit),
    .step_hit_o (step_hit)
  );

  assign hit_now = {step_hit, flow_hit, slot_hit};

  brk_status #(.NHIT(NHIT)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hit_i    (hit_now),
    .gen_i    (ctrl.gen),
    .clr_i    (brk_clr_i),
    .status_o (status)
  );

  assign brk_hit_o = status;
  assign brk_req_o = |status;

  // R4: the mask slot never reports on its own in pair mode
  a_r4_partner_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    ctrl.pair |-> !slot_hit[3]);

  // R6: a taken change of flow raises the flow status next cycle
  a_r6_flow: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pc_valid_i && pc_flow_i && ctrl.flow && ctrl.gen) |=> brk_hit_o[HIT_FLOW]);

  // R7: a completed instruction in step mode raises the step status
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pc_valid_i && ctrl.step && ctrl.gen) |=> brk_hit_o[HIT_STEP]);

  // R10: with idle streams and no set bit, the request stays low
  a_r10_no_comb: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pc_valid_i && !d_valid_i && !brk_req_o) |=> !brk_req_o);

endmodule

// File: tb/sim_brk_unit.sv
module sim_brk_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pv = 1'b0;
  logic [15:0] pc = '0;
  logic        fl = 1'b0;
  logic        dv = 1'b0;
  logic [15:0] da = '0;
  logic        dw = 1'b0;
  logic        clr = 1'b0;
  logic        req;
  logic [5:0]  hits;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brk_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pc_valid_i(pv), .pc_i(pc), .pc_flow_i(fl),
    .d_valid_i(dv), .d_addr_i(da), .d_we_i(dw), .brk_clr_i(clr),
    .brk_req_o(req), .brk_hit_o(hits)
  );

  typedef struct packed {
    logic [3:0]  req_no;
    logic [13:0] ctrl;
    logic [15:0] s3;
    logic        pv;
    logic [15:0] pc;
    logic        fl;
    logic        dv;
    logic [15:0] da;
    logic        dw;
    logic [5:0]  exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  14'h200F, 16'h0400, 1'b1, 16'h0100, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000001}, // R2 slot0
    '{4'd2,  14'h200F, 16'h0400, 1'b1, 16'h0200, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000010}, // R2 slot1
    '{4'd3,  14'h200F, 16'h0400, 1'b1, 16'h0300, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000100}, // R3 slot2 prog
    '{4'd3,  14'h200F, 16'h0400, 1'b1, 16'h0400, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b001000}, // R3 slot3 prog
    '{4'd2,  14'h200F, 16'h0400, 1'b1, 16'h0401, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000000}, // R2 miss
    '{4'd3,  14'h2214, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0300, 1'b0, 6'b000100}, // R3 data read
    '{4'd3,  14'h2214, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0300, 1'b1, 6'b000000}, // R3 write not allowed
    '{4'd3,  14'h2214, 16'h0400, 1'b1, 16'h0300, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000000}, // R3 data ignores pc
    '{4'd3,  14'h323C, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0400, 1'b1, 6'b001000}, // R3 slot3 data write
    '{4'd4,  14'h2044, 16'hFF00, 1'b1, 16'h03A5, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000100}, // R4 prog range in
    '{4'd4,  14'h2044, 16'hFF00, 1'b1, 16'h04A5, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000000}, // R4 prog range out
    '{4'd4,  14'h2674, 16'hFFF0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h030F, 1'b1, 6'b000100}, // R4 data range in
    '{4'd4,  14'h2674, 16'hFFF0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0310, 1'b1, 6'b000000}, // R4 data range out
    '{4'd6,  14'h2080, 16'h0400, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b010000}, // R6 flow
    '{4'd6,  14'h2080, 16'h0400, 1'b1, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000000}, // R6 sequential
    '{4'd7,  14'h2100, 16'h0400, 1'b1, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b100000}, // R7 step
    '{4'd8,  14'h018F, 16'h0400, 1'b1, 16'h0100, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000000}, // R8 global off
    '{4'd9,  14'h218F, 16'h0400, 1'b1, 16'h0100, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b110001}  // R9 several at once
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // drive one cycle of stream activity, return at the next falling edge
  task automatic drive(input logic p, input logic [15:0] a, input logic f,
                       input logic v, input logic [15:0] x, input logic w);
    @(negedge clk);
    pv = p; pc = a; fl = f; dv = v; da = x; dw = w;
    @(negedge clk);
    pv = 1'b0; fl = 1'b0; dv = 1'b0; dw = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, and nothing enabled
    chk("R1 hits", 16'(hits), 16'h0);
    chk("R1 req", 16'(req), 16'h0);
    drive(1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b1);
    chk("R1 no hit", 16'(hits), 16'h0);

    wr(3'd0, 16'h0100);
    wr(3'd1, 16'h0200);
    wr(3'd2, 16'h0300);

    for (int i = 0; i < NV; i++) begin
      wr(3'd3, VEC[i].s3);
      wr(3'd4, 16'(VEC[i].ctrl));
      clear();
      drive(VEC[i].pv, VEC[i].pc, VEC[i].fl, VEC[i].dv, VEC[i].da, VEC[i].dw);
      chk($sformatf("R%0d vector %0d hits", VEC[i].req_no, i), 16'(hits), 16'(VEC[i].exp));
      chk($sformatf("R%0d vector %0d req", VEC[i].req_no, i), 16'(req), 16'(|VEC[i].exp));
    end

    // R5: legal word, then two illegal words that would change matching
    wr(3'd4, 16'h2001);
    wr(3'd4, 16'h204C);
    wr(3'd4, 16'h2054);
    clear();
    drive(1'b1, 16'h0300, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R5 illegal rejected", 16'(hits), 16'h0);
    clear();
    drive(1'b1, 16'h0100, 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R5 previous kept", 16'(hits), 16'h01);

    // R10: no output before the capturing edge
    clear();
    @(negedge clk);
    pv = 1'b1; pc = 16'h0100;
    #1;
    chk("R10 before edge", 16'(hits), 16'h0);
    @(negedge clk);
    pv = 1'b0;
    chk("R10 after edge", 16'(hits), 16'h01);

    // R9: sticky, clear with simultaneous hit, plain clear
    repeat (3) @(negedge clk);
    chk("R9 held", 16'(hits), 16'h01);
    chk("R9 req held", 16'(req), 16'h1);
    @(negedge clk);
    clr = 1'b1; pv = 1'b1; pc = 16'h0100;
    @(negedge clk);
    clr = 1'b0; pv = 1'b0;
    chk("R9 hit with clear kept", 16'(hits), 16'h01);
    clear();
    chk("R9 cleared", 16'(hits), 16'h0);
    chk("R9 req cleared", 16'(req), 16'h0);

    finish_run();
  end

endmodule